// File: doc/BRIEF.md
# Transmit Bit-Clock Elastic Buffer

This block sits at the end of a serial transmit path, after the serializer and CRC stage. It lets the path take its bit clock from either of two sources. In internal mode the block drives the transmit clock pin from a divided system clock, and each serial bit goes straight to the transmit data pin. In external mode the pin becomes an input that an outside transceiver drives. A 16-entry, one-bit-wide elastic buffer then takes bits at the internal rate and gives them out on the rising edges of the external clock.

The upstream logic always runs from the internal divider in both modes. It is paced by a one-cycle request strobe. Because of this, the configured internal bit rate must match the rate the transceiver clocks at. Small phase differences are absorbed by the buffer. A real rate mismatch eventually shows up as one of two sticky error flags, one for overflow and one for underflow. Software clears each flag with a one-cycle pulse.

Top module: `txef_top`

## Requirements
- R1: A configuration write (`cfgWrEn` high for one cycle) loads the clock direction bit from `cfgExtClk`. A value of 1 selects external clock mode: `txClkOe` is 0 and `txClkOut` is held at 0. A value of 0 selects internal mode: `txClkOe` is 1 and `txClkOut` carries the divided clock. The new mode takes effect on the cycle after the write.
- R2: After reset the block is in external clock mode: `txClkOe`=0, `txClkOut`=0, `txData`=0, and both error flags are 0.
- R3: In internal mode, `txClkOut` has a period of DIV system clock cycles, with DIV=4 by default. It is low for the first DIV/2 cycles of each period and high for the rest. `bitReq` pulses for one cycle once per period, in the last high cycle.
- R4: In internal mode the buffer is bypassed. The bit on `bitIn` during a `bitReq` cycle appears on `txData` on the next cycle and is held for one full period.
- R5: In external mode `bitReq` keeps its pace of one pulse every DIV cycles, because the upstream logic stays on the internal clock.
- R6: In external mode, every bit presented during `bitReq` is written to the buffer. Reading on rising edges of `txClkIn` begins only once 8 bits (half of the 16 entries) are buffered; until then `txData` stays 0. After that, one bit leaves per rising edge, in the order written.
- R7: In external mode, a write when all 16 entries are occupied drops the bit and sets `errOver`. The flag stays set until it is cleared.
- R8: In external mode, a read edge that finds the buffer empty after reading has begun sets `errUnder`. Reading then pauses until 8 bits are buffered again. The flag stays set until it is cleared.
- R9: A pulse on `clrOver` or `clrUnder` clears the matching flag on the next cycle. If a new error event arrives in the same cycle, the set wins.
- R10: Selecting internal mode holds the buffer in reset. A later return to external mode starts with an empty buffer and waits for a new half fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the source of the internal bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | One-cycle strobe that loads the direction bit |
| cfgExtClk | input | 1 | Direction bit value: 1 external clock, 0 internal clock |
| clrOver | input | 1 | Clear pulse for the overflow flag |
| clrUnder | input | 1 | Clear pulse for the underflow flag |
| bitIn | input | 1 | Serial bit from the upstream stage |
| bitReq | output | 1 | Internal bit-rate strobe; `bitIn` is taken in this cycle |
| txClkIn | input | 1 | External bit clock from the transceiver |
| txClkOut | output | 1 | Divided clock driven onto the pin in internal mode |
| txClkOe | output | 1 | Output enable of the clock pin |
| txData | output | 1 | Transmit data pin |
| errOver | output | 1 | Sticky overflow flag |
| errUnder | output | 1 | Sticky underflow flag |

## Verification
Underflow and overflow are the hardest conditions to reach. The buffer recentres itself at half full, so a matched clock never produces either error. The bench first runs the external clock at the internal bit rate and checks the stream in order; a leading marker bit locks the comparison onto the first bit that is read out. It then speeds the external clock up until the buffer drains, which gives underflow. Finally it stops the external clock while the internal side keeps writing, which gives overflow. Switching back to internal mode and out again then shows that the buffer restarts empty.

// File: rtl/txef_pkg.sv
package txef_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;      // internal bit-rate strobe
    logic wrStrobe;  // write one bit into the elastic buffer
    logic fifoRun;   // external mode: buffer active, else held in reset
  } txefCtl_t;

  // error events from datapath to control, system-clock domain
  typedef struct packed {
    logic over;
    logic under;
  } txefEvt_t;

endpackage

// File: rtl/txef_ctrl.sv
module txef_ctrl
  import txef_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgWrEn,
  input  logic     cfgExtClk,
  input  logic     clrOver,
  input  logic     clrUnder,
  input  txefEvt_t evt,
  output txefCtl_t ctl,
  output logic     bitReq,
  output logic     txClkOut,
  output logic     txClkOe,
  output logic     errOver,
  output logic     errUnder
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF_DIV = DIV / 2;

  logic [CW-1:0] divCnt;
  logic          extMode;
  logic          divHigh;

  // clock direction bit, reset to input (external) mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        extMode <= 1'b1;
    else if (cfgWrEn) extMode <= cfgExtClk;
  end

  // free-running divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          divCnt <= '0;
    else if (divCnt == CW'(DIV - 1))    divCnt <= '0;
    else                                divCnt <= divCnt + 1'b1;
  end

  assign divHigh  = (divCnt >= CW'(HALF_DIV));
  assign bitReq   = (divCnt == CW'(DIV - 1));
  assign txClkOe  = ~extMode;
  assign txClkOut = ~extMode & divHigh;

  // sticky flags, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errOver  <= 1'b0;
      errUnder <= 1'b0;
    end else begin
      errOver  <= evt.over  | (errOver  & ~clrOver);
      errUnder <= evt.under | (errUnder & ~clrUnder);
    end
  end

  always_comb begin
    ctl.tick     = bitReq;
    ctl.wrStrobe = bitReq & extMode;
    ctl.fifoRun  = extMode;
  end

endmodule

// File: rtl/txef_path.sv
module txef_path
  import txef_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     txClkIn,
  input  txefCtl_t ctl,
  input  logic     bitIn,
  output logic     txData,
  output txefEvt_t evt
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DEPTH-1:0] mem;

  // ---------------- write side, system clock ----------------
  logic [PW-1:0] wPtr, wGray, rGrayS1, rGrayS2, wFill;
  logic          wFull, overPulse, directBit;
  logic [2:0]    uSync;

  assign wFill = wPtr - fromGray(rGrayS2);
  assign wFull = (wFill == PW'(DEPTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wPtr      <= '0;
      wGray     <= '0;
      rGrayS1   <= '0;
      rGrayS2   <= '0;
      overPulse <= 1'b0;
      uSync     <= '0;
    end else if (!ctl.fifoRun) begin
      wPtr      <= '0;
      wGray     <= '0;
      rGrayS1   <= '0;
      rGrayS2   <= '0;
      overPulse <= 1'b0;
      uSync     <= '0;
    end else begin
      rGrayS1   <= rGray;
      rGrayS2   <= rGrayS1;
      wGray     <= toGray(wPtr);
      overPulse <= ctl.wrStrobe & wFull;
      uSync     <= {uSync[1:0], underTgl};
      if (ctl.wrStrobe && !wFull) wPtr <= wPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.fifoRun && ctl.wrStrobe && !wFull) mem[wPtr[AW-1:0]] <= bitIn;
  end

  // bypass register for internal clock mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         directBit <= 1'b0;
    else if (ctl.tick) directBit <= bitIn;
  end

  // ---------------- read side, external clock ----------------
  logic          fifoRstN, rdRstN;
  logic [1:0]    rdRstPipe;
  logic [PW-1:0] rPtr, rGray, wGrayS1, wGrayS2, rFill;
  logic          started, rdBit, underTgl, rEmpty;

  assign fifoRstN = rstN & ctl.fifoRun;

  always_ff @(posedge txClkIn or negedge fifoRstN) begin
    if (!fifoRstN) rdRstPipe <= '0;
    else           rdRstPipe <= {rdRstPipe[0], 1'b1};
  end
  assign rdRstN = rdRstPipe[1];

  assign rFill  = fromGray(wGrayS2) - rPtr;
  assign rEmpty = (rFill == '0);

  always_ff @(posedge txClkIn or negedge rdRstN) begin
    if (!rdRstN) begin
      wGrayS1  <= '0;
      wGrayS2  <= '0;
      rPtr     <= '0;
      rGray    <= '0;
      started  <= 1'b0;
      rdBit    <= 1'b0;
      underTgl <= 1'b0;
    end else begin
      wGrayS1 <= wGray;
      wGrayS2 <= wGrayS1;
      rGray   <= toGray(rPtr);
      if (!started) begin
        if (rFill >= PW'(HALF)) started <= 1'b1;
      end else if (rEmpty) begin
        underTgl <= ~underTgl;
        started  <= 1'b0;
      end else begin
        rdBit <= mem[rPtr[AW-1:0]];
        rPtr  <= rPtr + 1'b1;
      end
    end
  end

  assign txData    = ctl.fifoRun ? rdBit : directBit;
  assign evt.over  = overPulse;
  assign evt.under = uSync[2] ^ uSync[1];

endmodule

// File: rtl/txef_top.sv
module txef_top
  import txef_pkg::*;
#(
  parameter int DIV   = 4,
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgWrEn,
  input  logic cfgExtClk,
  input  logic clrOver,
  input  logic clrUnder,
  input  logic bitIn,
  output logic bitReq,
  input  logic txClkIn,
  output logic txClkOut,
  output logic txClkOe,
  output logic txData,
  output logic errOver,
  output logic errUnder
);
  txefCtl_t ctl;
  txefEvt_t evt;

  txef_ctrl #(.DIV(DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgExtClk(cfgExtClk),
    .clrOver(clrOver), .clrUnder(clrUnder), .evt(evt), .ctl(ctl),
    .bitReq(bitReq), .txClkOut(txClkOut), .txClkOe(txClkOe),
    .errOver(errOver), .errUnder(errUnder)
  );

  txef_path #(.DEPTH(DEPTH)) path_i (
    .clk(clk), .rstN(rstN), .txClkIn(txClkIn), .ctl(ctl),
    .bitIn(bitIn), .txData(txData), .evt(evt)
  );

endmodule

// File: rtl/txef_chk.sv
module txef_chk
  import txef_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     cfgWrEn,
  input logic     cfgExtClk,
  input logic     clrOver,
  input logic     clrUnder,
  input logic     bitIn,
  input logic     bitReq,
  input logic     txClkOut,
  input logic     txClkOe,
  input logic     txData,
  input logic     errOver,
  input logic     errUnder,
  input txefCtl_t ctl,
  input txefEvt_t evt
);
  p_dir_follows_cfg_r1: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (txClkOe == !$past(cfgExtClk)));

  p_reset_input_r2: assert property (@(posedge clk)
    (!rstN && !cfgWrEn) |=> !txClkOe);

  p_req_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitReq |=> !bitReq);

  p_direct_path_r4: assert property (@(posedge clk) disable iff (!rstN)
    (bitReq && txClkOe && !cfgWrEn) |=> (txData == $past(bitIn)));

  p_idle_pin_r5: assert property (@(posedge clk) disable iff (!rstN)
    !txClkOe |-> !txClkOut);

  p_over_ext_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    evt.over |-> $past(ctl.fifoRun));

  p_over_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (errOver && !clrOver) |=> errOver);

  p_under_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (errUnder && !clrUnder) |=> errUnder);

  p_clear_over_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clrOver && !evt.over) |=> !errOver);

  p_clear_under_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clrUnder && !evt.under) |=> !errUnder);

  p_idle_events_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.fifoRun |=> !evt.over);
endmodule

bind txef_top txef_chk chk_i (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgExtClk(cfgExtClk),
  .clrOver(clrOver), .clrUnder(clrUnder), .bitIn(bitIn), .bitReq(bitReq),
  .txClkOut(txClkOut), .txClkOe(txClkOe), .txData(txData),
  .errOver(errOver), .errUnder(errUnder), .ctl(ctl), .evt(evt)
);

// File: tb/txef_top_tb_top.sv
`timescale 1ns/1ps
module txef_top_tb_top;
  logic clk = 1'b0, rstN = 1'b0, cfgWrEn = 1'b0, cfgExtClk = 1'b0;
  logic clrOver = 1'b0, clrUnder = 1'b0, bitIn = 1'b0, txClkIn = 1'b0;
  logic bitReq, txClkOut, txClkOe, txData, errOver, errUnder;

  txef_top dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgExtClk(cfgExtClk),
    .clrOver(clrOver), .clrUnder(clrUnder), .bitIn(bitIn), .bitReq(bitReq),
    .txClkIn(txClkIn), .txClkOut(txClkOut), .txClkOe(txClkOe),
    .txData(txData), .errOver(errOver), .errUnder(errUnder)
  );

  always #2 clk = ~clk;

  int  extHalf = 8;
  bit  extRun  = 1'b0;
  always begin
    if (extRun) begin
      #(extHalf) txClkIn = 1'b1;
      #(extHalf) txClkIn = 1'b0;
    end else #4;
  end

  int nRun = 0, nFail = 0, matchCnt = 0, pushCnt = 0, monMode = 0;
  bit q[$];
  bit drvOn = 1'b0, locked = 1'b0, prevClkOut = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: a new bit per request strobe, first bit is a 1 marker
  always @(negedge clk) begin
    if (drvOn && bitReq) begin
      bit b;
      b = (pushCnt == 0) ? 1'b1 : 1'($urandom_range(1));
      bitIn = b;
      q.push_back(b);
      pushCnt++;
    end
  end

  // monitor, internal mode: data read at each rising edge of the pin clock
  always @(posedge clk) begin
    #1;
    if (monMode == 1 && txClkOut && !prevClkOut && q.size() > 0) begin
      bit e;
      e = q.pop_front();
      chk(txData == e, "R4", txData, e);
      matchCnt++;
    end
    prevClkOut = txClkOut;
  end

  // monitor, external mode: sample between external edges
  always @(negedge txClkIn) begin
    if (monMode == 2) begin
      if (!locked) begin
        if (txData) begin
          locked = 1'b1;
          chk(pushCnt >= 8, "R6", pushCnt, 8);
          if (q.size() > 0) void'(q.pop_front());
        end
      end else if (q.size() == 0) begin
        chk(1'b0, "R6", 0, 1);
      end else begin
        bit e;
        e = q.pop_front();
        chk(txData == e, "R6", txData, e);
        matchCnt++;
      end
    end
  end

  task automatic cfgWrite(input bit v);
    @(negedge clk); cfgWrEn = 1'b1; cfgExtClk = v;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) clrOver = 1'b1; else clrUnder = 1'b1;
    @(negedge clk);
    clrOver = 1'b0; clrUnder = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int cnt, bad, waitCnt;
    // reset state
    repeat (5) @(negedge clk);
    chk(txClkOe == 1'b0, "R2", txClkOe, 0);
    chk(txClkOut == 1'b0, "R2", txClkOut, 0);
    chk(txData == 1'b0, "R2", txData, 0);
    chk(errOver == 1'b0 && errUnder == 1'b0, "R2", errOver + errUnder, 0);
    rstN = 1'b1;

    // external mode after reset: internal pace kept, pin idle
    cnt = 0; bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (bitReq) cnt++;
      if (txClkOut || txClkOe) bad++;
    end
    chk(cnt == 10, "R5", cnt, 10);
    chk(bad == 0, "R5", bad, 0);

    // internal clock mode
    cfgWrite(1'b0);
    chk(txClkOe == 1'b1, "R1", txClkOe, 1);
    cnt = 0; bad = 0;
    begin
      bit prev;
      prev = txClkOut;
      repeat (40) begin
        @(negedge clk);
        if (txClkOut && !prev) cnt++;
        if (bitReq && !txClkOut) bad++;
        prev = txClkOut;
      end
    end
    chk(cnt == 10, "R3", cnt, 10);
    chk(bad == 0, "R3", bad, 0);

    q.delete(); pushCnt = 0; matchCnt = 0;
    drvOn = 1'b1; monMode = 1;
    repeat (200) @(negedge clk);
    drvOn = 1'b0; monMode = 0;
    repeat (8) @(negedge clk);
    chk(matchCnt >= 40, "R4", matchCnt, 40);

    // external mode, matched rates
    cfgWrite(1'b1);
    chk(txClkOe == 1'b0, "R1", txClkOe, 0);
    chk(txClkOut == 1'b0, "R1", txClkOut, 0);
    q.delete(); pushCnt = 0; matchCnt = 0; locked = 1'b0;
    drvOn = 1'b1; monMode = 2; extHalf = 8; extRun = 1'b1;
    repeat (1000) @(negedge clk);
    monMode = 0;
    chk(locked == 1'b1, "R6", locked, 1);
    chk(matchCnt >= 200, "R6", matchCnt, 200);
    chk(errOver == 1'b0 && errUnder == 1'b0, "R6", errOver + errUnder, 0);

    // external clock too fast: underflow
    extHalf = 6;
    waitCnt = 0;
    while (!errUnder && waitCnt < 4000) begin @(negedge clk); waitCnt++; end
    chk(errUnder == 1'b1, "R8", errUnder, 1);
    chk(errOver == 1'b0, "R8", errOver, 0);
    extRun = 1'b0;
    repeat (50) @(negedge clk);
    chk(errUnder == 1'b1, "R8", errUnder, 1);

    // external clock stopped, writes continue: overflow
    waitCnt = 0;
    while (!errOver && waitCnt < 1000) begin @(negedge clk); waitCnt++; end
    chk(errOver == 1'b1, "R7", errOver, 1);
    pulse(1);
    chk(errUnder == 1'b0, "R9", errUnder, 1'b0);
    repeat (20) @(negedge clk);
    chk(errOver == 1'b1, "R7", errOver, 1);

    // leave external mode, then clear overflow
    drvOn = 1'b0;
    cfgWrite(1'b0);
    repeat (4) @(negedge clk);
    pulse(0);
    chk(errOver == 1'b0, "R9", errOver, 0);

    // return to external mode: buffer starts empty
    extHalf = 8; extRun = 1'b1;
    repeat (10) @(negedge clk);
    cfgWrite(1'b1);
    q.delete(); pushCnt = 0; matchCnt = 0; locked = 1'b0;
    drvOn = 1'b1; monMode = 2;
    repeat (800) @(negedge clk);
    monMode = 0; drvOn = 1'b0;
    chk(locked == 1'b1, "R10", locked, 1);
    chk(matchCnt >= 150, "R10", matchCnt, 150);
    chk(errOver == 1'b0 && errUnder == 1'b0, "R10", errOver + errUnder, 0);

    summary();
  end
endmodule